// File: doc/BRIEF.md
# Big-Endian Byte-Addressed RAM Port

This block is a single-port random access memory of 2^P bytes that serves 8-bit, 16-bit and 32-bit transfers through one request interface. Multi-byte values are laid out with the most significant byte at the lowest address. Reads are registered: the requested value appears on the read-data output one clock after the request. The value is widened to 32 bits by sign or zero extension, as chosen by a flag that comes with the request.

The block never faults on an address. Any address bit at or above bit P is discarded, so accesses wrap around the array. A 16-bit access silently drops address bit 0, and a 32-bit access drops bits 1 and 0, so the transfer always lands on its natural boundary. The storage is four byte-wide lanes, one for each byte position in a 32-bit row. A write drives only the lanes its size and offset cover. A synchronous active-low reset clears every byte to zero.

Top module: `be_masked_mem`

## Requirements
- R1: After reset every byte of the array reads as zero, for every access size.
- R2: Big-endian order: after a 32-bit write of value V to aligned address A, byte A holds V[31:24], A+1 holds V[23:16], A+2 holds V[15:8] and A+3 holds V[7:0]. A 16-bit write of H to A puts H[15:8] at A and H[7:0] at A+1.
- R3: A write changes only the bytes covered by its size: one byte for an 8-bit write, two for a 16-bit write, four for a 32-bit write. Every other byte keeps its value.
- R4: Alignment by masking: a 16-bit access ignores address bit 0, and a 32-bit access ignores address bits 1:0, for both reads and writes.
- R5: Wrap-around: address bits P and above have no effect, so address A+2^P reaches the same byte as A.
- R6: 8-bit reads with the signed flag set copy bit 7 into bits 31:8. With the flag clear, bits 31:8 are zero.
- R7: 16-bit reads with the signed flag set copy bit 15 into bits 31:16. With the flag clear, bits 31:16 are zero.
- R8: Read data is valid in the cycle after a read request (req=1, we=0). It holds its value in every cycle that follows a cycle without a read request, and writes included.
- R9: Size encoding on `size`: 0 selects 8 bits, 1 selects 16 bits, and 2 and 3 both select 32 bits. For 32-bit reads the signed flag has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears the array and read data |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read (qualified by req) |
| size | input | 2 | Access size: 0 byte, 1 half-word, 2/3 long |
| signed_rd | input | 1 | Sign-extend narrow reads when 1 |
| addr | input | 32 | Byte address; bits P and above are discarded |
| wdata | input | 32 | Write data, right-justified for narrow sizes |
| rdata | output | 32 | Read data, extended to 32 bits, one clock after the read |

## Verification
The in-RTL assertions check on every cycle that:
- a write enables exactly as many byte lanes as its size requires;
- a 16-bit write enables either the upper or the lower lane pair;
- narrow reads produce correctly extended upper bits;
- read data stays put after any cycle without a read.

The actual byte placement, the masking of low and high address bits, and the preservation of untouched bytes depend on stored contents, so only the bench's scenarios show them. The bench compares those scenarios against its own byte-array model.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;

  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_HALF = 2'd1,
    XS_LONG = 2'd2,
    XS_LNG3 = 2'd3
  } xfer_size_e;

  // Offset inside a 32-bit row after forcing natural alignment.
  function automatic logic [1:0] align_off(input logic [1:0] sz, input logic [1:0] raw);
    case (sz)
      2'd0:    align_off = raw;
      2'd1:    align_off = {raw[1], 1'b0};
      default: align_off = 2'b00;
    endcase
  endfunction

  // Lane enables; bit i means byte offset i inside the row.
  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0:    lane_mask = 4'b0001 << off;
      2'd1:    lane_mask = off[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // Replicate write data so that every enabled lane sees its byte.
  // Row bits [31-8i -: 8] belong to byte offset i (big-endian).
  function automatic logic [31:0] place_wdata(input logic [1:0] sz, input logic [31:0] wd);
    case (sz)
      2'd0:    place_wdata = {4{wd[7:0]}};
      2'd1:    place_wdata = {2{wd[15:0]}};
      default: place_wdata = wd;
    endcase
  endfunction

  // Pick the addressed bytes out of a row and extend them to 32 bits.
  function automatic logic [31:0] extract_rd(input logic [1:0] sz, input logic [1:0] off,
                                             input logic sgn, input logic [31:0] row);
    logic [7:0]  b;
    logic [15:0] h;
    b = 8'(row >> (8 * (3 - int'(off))));
    h = off[1] ? row[15:0] : row[31:16];
    case (sz)
      2'd0:    extract_rd = {{24{sgn & b[7]}}, b};
      2'd1:    extract_rd = {{16{sgn & h[15]}}, h};
      default: extract_rd = row;
    endcase
  endfunction

endpackage

// File: rtl/be_addr_decode.sv
module be_addr_decode
  import be_mem_pkg::*;
#(
  parameter int P = 10,
  localparam int ROW_W = P - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       size,
  input  logic [31:0]      addr,
  input  logic [31:0]      wdata,
  output logic [ROW_W-1:0] row,
  output logic [1:0]       off,
  output logic [3:0]       lane_we,
  output logic [31:0]      lane_wd
);
  localparam logic [31:0] ADDR_MASK = 32'((64'd1 << P) - 64'd1);

  always_comb begin
    row     = ROW_W'((addr & ADDR_MASK) >> 2);
    off     = align_off(size, addr[1:0]);
    lane_we = wr_en ? lane_mask(size, off) : 4'b0000;
    lane_wd = place_wdata(size, wdata);
  end

  // R3: number of written lanes matches the access size
  a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $countones(lane_we) == ((size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4));

  // R4: half-word writes hit an aligned lane pair
  a_r4_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == 2'd1) |-> (lane_we == 4'b1100 || lane_we == 4'b0011));

  a_r3_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> lane_we == 4'b0000);
endmodule

// File: rtl/be_byte_lane.sv
module be_byte_lane #(
  parameter int ROW_W = 8,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wbyte,
  output logic [7:0]       rbyte
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (wr) begin
      cells[row] <= wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rbyte <= 8'h00;
    else if (rd) rbyte <= cells[row];
  end
endmodule

// File: rtl/be_read_format.sv
module be_read_format
  import be_mem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd,
  input  logic [1:0]  size,
  input  logic [1:0]  off,
  input  logic        signed_rd,
  input  logic [31:0] row_q,
  output logic [31:0] rdata
);
  logic [1:0] size_q;
  logic [1:0] off_q;
  logic       sgn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= 2'd2;
      off_q  <= 2'd0;
      sgn_q  <= 1'b0;
    end else if (rd) begin
      size_q <= size;
      off_q  <= off;
      sgn_q  <= signed_rd;
    end
  end

  assign rdata = extract_rd(size_q, off_q, sgn_q, row_q);

  // R6: byte reads extend bit 7 or fill with zero
  a_r6_byte_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == 2'd0) |-> rdata[31:8] == (sgn_q ? {24{rdata[7]}} : 24'h0));

  // R7: half-word reads extend bit 15 or fill with zero
  a_r7_half_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == 2'd1) |-> rdata[31:16] == (sgn_q ? {16{rdata[15]}} : 16'h0));
endmodule

// File: rtl/be_masked_mem.sv
module be_masked_mem
  import be_mem_pkg::*;
#(
  parameter int P = 10,
  localparam int ROW_W = P - 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [1:0]  size,
  input  logic        signed_rd,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic             wr_en;
  logic             rd_en;
  logic [ROW_W-1:0] row;
  logic [1:0]       off;
  logic [3:0]       lane_we;
  logic [31:0]      lane_wd;
  logic [31:0]      row_q;

  assign wr_en = req & we;
  assign rd_en = req & ~we;

  be_addr_decode #(.P(P)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .size(size), .addr(addr),
    .wdata(wdata), .row(row), .off(off), .lane_we(lane_we), .lane_wd(lane_wd)
  );

  for (genvar g = 0; g < 4; g++) begin : g_lane
    be_byte_lane #(.ROW_W(ROW_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .wr(lane_we[g]), .rd(rd_en), .row(row),
      .wbyte(lane_wd[31-8*g -: 8]), .rbyte(row_q[31-8*g -: 8])
    );
  end

  be_read_format u_fmt (
    .clk(clk), .rst_n(rst_n), .rd(rd_en), .size(size), .off(off),
    .signed_rd(signed_rd), .row_q(row_q), .rdata(rdata)
  );

  // R8: output holds after any cycle without a read request
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R9: reads never write
  a_r9_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> lane_we == 4'b0000);
endmodule

// File: tb/tb_be_masked_mem.sv
module tb_be_masked_mem;
  localparam int P = 10;
  localparam int NB = 1 << P;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic        signed_rd = 1'b0;
  logic [31:0] addr = 32'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [NB];

  be_masked_mem #(.P(P)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size),
    .signed_rd(signed_rd), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic int base_of(input logic [1:0] sz, input logic [31:0] a);
    int m;
    m = int'(a % NB);
    if (sz == 2'd1) m = m - (m % 2);
    else if (sz >= 2'd2) m = m - (m % 4);
    return m;
  endfunction

  function automatic logic [31:0] model_rd(input logic [1:0] sz, input logic s, input logic [31:0] a);
    int b;
    logic [31:0] v;
    b = base_of(sz, a);
    if (sz == 2'd0) begin
      v = {24'h0, model[b]};
      if (s && model[b][7]) v[31:8] = 24'hffffff;
    end else if (sz == 2'd1) begin
      v = {16'h0, model[b], model[b+1]};
      if (s && model[b][7]) v[31:16] = 16'hffff;
    end else begin
      v = {model[b], model[b+1], model[b+2], model[b+3]};
    end
    return v;
  endfunction

  task automatic wr(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    int b;
    @(negedge clk);
    req = 1; we = 1; size = sz; addr = a; wdata = d;
    b = base_of(sz, a);
    if (sz == 2'd0) model[b] = d[7:0];
    else if (sz == 2'd1) begin model[b] = d[15:8]; model[b+1] = d[7:0]; end
    else begin
      model[b] = d[31:24]; model[b+1] = d[23:16];
      model[b+2] = d[15:8]; model[b+3] = d[7:0];
    end
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input string tag, input logic [1:0] sz, input logic s,
                    input logic [31:0] a, input logic [31:0] exp);
    @(negedge clk);
    req = 1; we = 0; size = sz; signed_rd = s; addr = a;
    @(negedge clk);
    req = 0;
    check(tag, rdata, exp);
  endtask

  task automatic t_reset();
    rd("R1 byte zero", 2'd0, 1'b1, 32'd7, 32'h0);
    rd("R1 long zero", 2'd2, 1'b0, 32'd512, 32'h0);
  endtask

  task automatic t_endian();
    wr(2'd2, 32'd16, 32'h8123_45F6);
    rd("R2 byte0", 2'd0, 1'b0, 32'd16, 32'h0000_0081);
    rd("R2 byte3", 2'd0, 1'b0, 32'd19, 32'h0000_00F6);
    rd("R2 half2", 2'd1, 1'b0, 32'd18, 32'h0000_45F6);
    wr(2'd1, 32'd40, 32'h0000_A55A);
    rd("R2 half bytes", 2'd0, 1'b0, 32'd41, 32'h0000_005A);
  endtask

  task automatic t_partial();
    wr(2'd2, 32'd64, 32'h1122_3344);
    wr(2'd0, 32'd66, 32'h0000_00EE);
    rd("R3 byte write", 2'd2, 1'b0, 32'd64, 32'h1122_EE44);
    wr(2'd1, 32'd64, 32'h0000_BEEF);
    rd("R3 half write", 2'd2, 1'b0, 32'd64, 32'hBEEF_EE44);
    rd("R3 neighbour", 2'd2, 1'b0, 32'd68, model_rd(2'd2, 1'b0, 32'd68));
  endtask

  task automatic t_align();
    wr(2'd2, 32'd83, 32'hCAFE_0123);
    rd("R4 long write aligned", 2'd2, 1'b0, 32'd80, 32'hCAFE_0123);
    rd("R4 long read low bits", 2'd2, 1'b0, 32'd82, 32'hCAFE_0123);
    wr(2'd1, 32'd97, 32'h0000_7788);
    rd("R4 half aligned", 2'd0, 1'b0, 32'd96, 32'h0000_0077);
    rd("R4 half read odd", 2'd1, 1'b0, 32'd97, 32'h0000_7788);
  endtask

  task automatic t_wrap();
    wr(2'd2, NB + 32'd120, 32'hDEAD_BEEF);
    rd("R5 wrapped write", 2'd2, 1'b0, 32'd120, 32'hDEAD_BEEF);
    rd("R5 wrapped read", 2'd0, 1'b0, 32'hF000_0000 + 32'd121, 32'h0000_00AD);
  endtask

  task automatic t_ext();
    wr(2'd2, 32'd200, 32'h80FF_7F01);
    rd("R6 signed byte neg", 2'd0, 1'b1, 32'd200, 32'hFFFF_FF80);
    rd("R6 unsigned byte", 2'd0, 1'b0, 32'd201, 32'h0000_00FF);
    rd("R6 signed byte pos", 2'd0, 1'b1, 32'd202, 32'h0000_007F);
    rd("R7 signed half neg", 2'd1, 1'b1, 32'd200, 32'hFFFF_80FF);
    rd("R7 unsigned half", 2'd1, 1'b0, 32'd200, 32'h0000_80FF);
    rd("R7 signed half pos", 2'd1, 1'b1, 32'd202, 32'h0000_7F01);
    rd("R9 long ignores sign", 2'd2, 1'b1, 32'd200, 32'h80FF_7F01);
  endtask

  task automatic t_size3_hold();
    wr(2'd3, 32'd300, 32'h0102_0304);
    rd("R9 size3 long write", 2'd2, 1'b0, 32'd300, 32'h0102_0304);
    rd("R9 size3 long read", 2'd3, 1'b1, 32'd302, 32'h0102_0304);
    wr(2'd2, 32'd304, 32'hFFFF_FFFF);
    check("R8 hold across write", rdata, 32'h0102_0304);
    @(negedge clk);
    addr = 32'd304;
    @(negedge clk);
    check("R8 hold idle", rdata, 32'h0102_0304);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 rdata after reset", rdata, 32'h0);
    t_reset();
    t_endian();
    t_partial();
    t_align();
    t_wrap();
    t_ext();
    t_size3_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule